// File: doc/BRIEF.md
# SPI Master Status and Flag Unit

This block is a byte-wide SPI master with a small register window. A processor writes a byte into the data register, which goes straight into the shift register and starts a transfer on SCK/MOSI/MISO when the block is in master mode. When the eighth clock has finished, the received byte is copied into a read buffer and a completion flag is raised. Reading the data register returns that buffered byte, so a new transfer can start without losing the last result.

Three sticky status flags report completion, a data write made while a transfer was running, and a mode fault. A mode fault is a low level on the slave-select input while master mode is on. Each flag is cleared by a two-step handshake. First the status register is read while the flag is set. Then an access follows: a data-register access for completion and collision, or a control-register write for a mode fault. A fault also drops master mode and cancels any transfer in progress. When slave select is configured as an output, fault detection is disabled. The interrupt line combines completion and mode fault under an enable bit.

Top module: `spi_flag_ctl`

## Requirements
- R1: The completion flag (status bit 7) rises only after the eighth SCK cycle of a transfer has finished. It is still 0 while the transfer runs.
- R2: The completion flag clears only when a data-register read or write follows a status read that saw it set. A data access without that read, or a control write, leaves it set.
- R3: A data write (address 2) made while a transfer runs sets the collision flag (status bit 6). The written byte is dropped, and the byte already shifting leaves on MOSI unchanged.
- R4: The collision flag never drives the interrupt. It clears through the same status-read-then-data-access handshake as the completion flag.
- R5: With master mode on (control bit 0) and slave select as an input, a low slave-select input sets the mode-fault flag (status bit 4).
- R6: A mode fault clears the master control bit, leaves the interrupt-enable bit alone, and aborts a running transfer without setting the completion flag.
- R7: While the slave-select direction input is 1 (pin used as an output), the mode-fault flag stays 0 and master mode is kept.
- R8: The mode-fault flag clears only when a control-register write (address 0) follows a status read that saw it set. Data accesses do not clear it.
- R9: A data read returns the last completed received byte. A data write loads the shifter directly, and the shifter sends most significant bit first.
- R10: The status register (address 1) is read-only, resets to 0, and reads 0 in every bit except 7, 6 and 4. Writes to it change nothing.
- R11: The interrupt output is high exactly when the enable bit (control bit 1) is set and the completion or mode-fault flag is set.
- R12: If a flag that has been armed by a status read sets again before the second access, the arming is cancelled, and that second access leaves the flag set.
- R13: SCK idles low. MOSI changes on falling SCK edges and MISO is sampled on rising ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the selected register |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Slave-select input, active low |
| ss_is_out_i | input | 1 | 1 when the slave-select pin is configured as an output |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the handshake ordering. It checks that a data access with no status read first leaves the completion flag set, that a write to the status register does not disturb an armed clear, and that a collision repeated after arming survives the second access. A design that cleared on any single access, or that kept the arming after a new set, would read 0 where the bench expects C0 or 80. It also checks that the byte on MOSI after a collision is the first byte written, that a mode fault ends a running transfer with no completion flag and with SCK low, and that a fault is suppressed while slave select is an output. A design that let the dropped write through, that finished the aborted transfer, or that ignored the direction input would show a wrong byte, a stray completion flag, or a fault flag.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
   typedef enum logic [1:0] {
      REG_CTL   = 2'd0,
      REG_STAT  = 2'd1,
      REG_DATA  = 2'd2,
      REG_SPARE = 2'd3
   } spi_reg_e;

   localparam int ST_DONE_BIT = 7;
   localparam int ST_WCOL_BIT = 6;
   localparam int ST_MODF_BIT = 4;
   localparam int CTL_MST_BIT = 0;
   localparam int CTL_IE_BIT  = 1;

   localparam int FLAG_DONE = 0;
   localparam int FLAG_WCOL = 1;
   localparam int FLAG_MODF = 2;
   localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/spi_ss_sync.sv
module spi_ss_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 1) begin : g_bad
      $error("spi_ss_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b1;
         else        q <= d_i;
      end
      assign q_o = q;
   end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '1;
         else        sh <= {sh[STAGES-2:0], d_i};
      end
      assign q_o = sh[STAGES-1];
   end
endmodule

// File: rtl/spi_sticky_flag.sv
module spi_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic stat_rd_i,
   input  logic clr_acc_i,
   output logic flag_o
);
   logic flag_q;
   logic arm_q;

   // a new set always wins and cancels a pending arm
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         arm_q  <= 1'b0;
      end else if (set_i) begin
         flag_q <= 1'b1;
         arm_q  <= 1'b0;
      end else if (arm_q && clr_acc_i) begin
         flag_q <= 1'b0;
         arm_q  <= 1'b0;
      end else if (stat_rd_i && flag_q) begin
         arm_q  <= 1'b1;
      end
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine #(
   parameter int DATA_W   = 8,
   parameter int DIV_HALF = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              go_i,
   input  logic [DATA_W-1:0] load_data_i,
   input  logic              abort_i,
   input  logic              miso_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rx_o,
   output logic              sck_o,
   output logic              mosi_o
);
   localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_HALF - 1);
   localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W - 1);

   if (DIV_HALF < 1) begin : g_bad_div
      $error("spi_xfer_engine: DIV_HALF must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_w
      $error("spi_xfer_engine: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] rx_buf;
   logic [DIV_W-1:0]  div_cnt;
   logic [CNT_W-1:0]  bit_cnt;
   logic              busy_q;
   logic              done_q;
   logic              sck_q;
   logic              rx_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         rx_buf  <= '0;
         div_cnt <= '0;
         bit_cnt <= '0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         sck_q   <= 1'b0;
         rx_bit  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (abort_i) begin
            busy_q  <= 1'b0;
            sck_q   <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
         end else if (load_i && !busy_q) begin
            shreg   <= load_data_i;
            busy_q  <= go_i;
            sck_q   <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
         end else if (busy_q) begin
            if (div_cnt == DIV_LAST) begin
               div_cnt <= '0;
               sck_q   <= ~sck_q;
               if (!sck_q) begin
                  rx_bit <= miso_i;
               end else begin
                  shreg <= {shreg[DATA_W-2:0], rx_bit};
                  if (bit_cnt == BIT_LAST) begin
                     busy_q  <= 1'b0;
                     done_q  <= 1'b1;
                     rx_buf  <= {shreg[DATA_W-2:0], rx_bit};
                     bit_cnt <= '0;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
            end else begin
               div_cnt <= div_cnt + 1'b1;
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign done_o = done_q;
   assign rx_o   = rx_buf;
   assign sck_o  = sck_q;
   assign mosi_o = shreg[DATA_W-1];
endmodule

// File: rtl/spi_flag_ctl.sv
module spi_flag_ctl
   import spi_flag_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int DIV_HALF = 2,
   parameter int SS_SYNC  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              sck_o,
   output logic              mosi_o,
   input  logic              miso_i,
   input  logic              ss_n_i,
   input  logic              ss_is_out_i,
   output logic              irq_o
);
   if (DATA_W < 8) begin : g_bad_w
      $error("spi_flag_ctl: DATA_W must be at least 8");
   end

   logic wr_ctl, wr_data, rd_stat, data_acc;
   logic ss_q, fault_evt;
   logic ctl_mst, ctl_ie;
   logic xfer_busy, xfer_done;
   logic [DATA_W-1:0] rx_byte;
   logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;
   logic flag_done, flag_wcol, flag_modf;

   assign wr_ctl   = bus_wr && (bus_addr == REG_CTL);
   assign wr_data  = bus_wr && (bus_addr == REG_DATA);
   assign rd_stat  = bus_rd && (bus_addr == REG_STAT);
   assign data_acc = (bus_rd || bus_wr) && (bus_addr == REG_DATA);

   spi_ss_sync #(.STAGES(SS_SYNC)) u_ss_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ss_n_i),
      .q_o   (ss_q)
   );

   assign fault_evt = ctl_mst && !ss_is_out_i && !ss_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_mst <= 1'b0;
         ctl_ie  <= 1'b0;
      end else begin
         if (wr_ctl) ctl_ie <= bus_wdata[CTL_IE_BIT];
         if (fault_evt)   ctl_mst <= 1'b0;
         else if (wr_ctl) ctl_mst <= bus_wdata[CTL_MST_BIT];
      end
   end

   spi_xfer_engine #(.DATA_W(DATA_W), .DIV_HALF(DIV_HALF)) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (wr_data),
      .go_i        (ctl_mst),
      .load_data_i (bus_wdata),
      .abort_i     (fault_evt),
      .miso_i      (miso_i),
      .busy_o      (xfer_busy),
      .done_o      (xfer_done),
      .rx_o        (rx_byte),
      .sck_o       (sck_o),
      .mosi_o      (mosi_o)
   );

   always_comb begin
      flag_set            = '0;
      flag_clr            = '0;
      flag_set[FLAG_DONE] = xfer_done;
      flag_set[FLAG_WCOL] = wr_data && xfer_busy;
      flag_set[FLAG_MODF] = fault_evt;
      flag_clr[FLAG_DONE] = data_acc;
      flag_clr[FLAG_WCOL] = data_acc;
      flag_clr[FLAG_MODF] = wr_ctl;
   end

   for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
      spi_sticky_flag u_flag (
         .clk       (clk),
         .rst_n     (rst_n),
         .set_i     (flag_set[gi]),
         .stat_rd_i (rd_stat),
         .clr_acc_i (flag_clr[gi]),
         .flag_o    (flag_q[gi])
      );
   end

   assign flag_done = flag_q[FLAG_DONE];
   assign flag_wcol = flag_q[FLAG_WCOL];
   assign flag_modf = flag_q[FLAG_MODF];

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         REG_CTL: begin
            bus_rdata[CTL_MST_BIT] = ctl_mst;
            bus_rdata[CTL_IE_BIT]  = ctl_ie;
         end
         REG_STAT: begin
            bus_rdata[ST_DONE_BIT] = flag_done;
            bus_rdata[ST_WCOL_BIT] = flag_wcol;
            bus_rdata[ST_MODF_BIT] = flag_modf;
         end
         REG_DATA:  bus_rdata = rx_byte;
         default:   bus_rdata = '0;
      endcase
   end

   assign irq_o = ctl_ie && (flag_done || flag_modf);
endmodule

// File: rtl/spi_flag_ctl_chk.sv
module spi_flag_ctl_chk
   import spi_flag_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq_o,
   input logic              sck_o,
   input logic              ss_is_out_i,
   input logic              flag_done,
   input logic              flag_wcol,
   input logic              flag_modf,
   input logic              xfer_busy,
   input logic              ctl_mst,
   input logic              ctl_ie
);
   a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_done && !((bus_rd || bus_wr) && bus_addr == REG_DATA)) |=> flag_done);

   a_r3_collision_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_DATA && xfer_busy) |=> flag_wcol);

   a_r11_quiet_irq: assert property (@(posedge clk) disable iff (!rst_n)
      ((!flag_done && !flag_modf) || !ctl_ie) |-> !irq_o);

   a_r6_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_modf) |-> (!ctl_mst && !xfer_busy));

   a_r7_fault_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_is_out_i && !flag_modf) |=> !flag_modf);

   a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_modf && !(bus_wr && bus_addr == REG_CTL)) |=> flag_modf);

   a_r10_stat_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == REG_STAT) |-> (bus_rdata[5] == 1'b0 && bus_rdata[3:0] == 4'h0));

   a_r13_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_busy |-> !sck_o);
endmodule

bind spi_flag_ctl spi_flag_ctl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_rd      (bus_rd),
   .bus_wr      (bus_wr),
   .bus_rdata   (bus_rdata),
   .irq_o       (irq_o),
   .sck_o       (sck_o),
   .ss_is_out_i (ss_is_out_i),
   .flag_done   (flag_done),
   .flag_wcol   (flag_wcol),
   .flag_modf   (flag_modf),
   .xfer_busy   (xfer_busy),
   .ctl_mst     (ctl_mst),
   .ctl_ie      (ctl_ie)
);

// File: tb/spi_flag_ctl_tb.sv
`timescale 1ns/1ps
module spi_flag_ctl_tb;
   localparam logic [1:0] A_CTL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;
   localparam logic [1:0] OP_RD = 2'd1, OP_WR = 2'd2, OP_WAIT = 2'd3;
   localparam int NV = 23;
   // {op, addr, data, req}: reads compare data, writes drive it
   localparam logic [15:0] VEC [0:NV-1] = '{
      {OP_RD,   A_STAT, 8'h00, 4'd10},  // R10 reset value
      {OP_RD,   A_CTL,  8'h00, 4'd10},  // R10 control resets too
      {OP_WR,   A_CTL,  8'h03, 4'd0},
      {OP_RD,   A_CTL,  8'h03, 4'd5},   // R5 master mode on
      {OP_WR,   A_DATA, 8'h5A, 4'd0},
      {OP_WR,   A_DATA, 8'hFF, 4'd0},   // collides
      {OP_RD,   A_STAT, 8'h40, 4'd3},   // R3 collision, R1 not yet done
      {OP_WAIT, A_CTL,  8'h00, 4'd0},
      {OP_RD,   A_STAT, 8'hC0, 4'd1},   // R1 done after 8 clocks
      {OP_RD,   A_DATA, 8'hA5, 4'd9},   // R9 buffered byte
      {OP_RD,   A_STAT, 8'h00, 4'd4},   // R4 collision cleared with done
      {OP_WR,   A_DATA, 8'h81, 4'd0},
      {OP_WAIT, A_CTL,  8'h00, 4'd0},
      {OP_RD,   A_DATA, 8'hA5, 4'd9},   // R9, no arming read before
      {OP_RD,   A_STAT, 8'h80, 4'd2},   // R2 still set
      {OP_WR,   A_DATA, 8'hC3, 4'd0},   // clears and starts
      {OP_RD,   A_STAT, 8'h00, 4'd2},   // R2 cleared by write
      {OP_WAIT, A_CTL,  8'h00, 4'd0},
      {OP_RD,   A_STAT, 8'h80, 4'd1},   // R1
      {OP_WR,   A_STAT, 8'hFF, 4'd0},
      {OP_RD,   A_STAT, 8'h80, 4'd10},  // R10 write ignored
      {OP_RD,   A_DATA, 8'hA5, 4'd9},   // R9
      {OP_RD,   A_STAT, 8'h00, 4'd2}    // R2
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       sck_o, mosi_o, irq_o;
   logic       ss_n_i = 1'b1, ss_is_out_i = 1'b0;
   logic [7:0] slave_tx = 8'hA5, slave_rx = 8'h00;
   logic [2:0] slave_cnt = 3'd0;
   int         n_chk = 0, n_fail = 0;
   bit         finished = 1'b0;
   logic [7:0] got;

   always #2 clk = ~clk;

   spi_flag_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(slave_tx[7]),
      .ss_n_i(ss_n_i), .ss_is_out_i(ss_is_out_i), .irq_o(irq_o)
   );

   // simple slave: captures MOSI on rising SCK, shifts on falling SCK
   always @(posedge sck_o) slave_rx <= {slave_rx[6:0], mosi_o};
   always @(negedge sck_o) begin
      if (slave_cnt == 3'd7) slave_tx <= 8'hA5;
      else                   slave_tx <= {slave_tx[6:0], 1'b0};
      slave_cnt <= slave_cnt + 3'd1;
   end

   task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      #1;
      check(13, {7'd0, sck_o}, 8'h00);   // R13 idle low
      check(11, {7'd0, irq_o}, 8'h00);   // R11 quiet after reset

      for (int i = 0; i < NV; i++) begin
         case (VEC[i][15:14])
            OP_RD: begin
               bus_read(VEC[i][13:12], got);
               check(int'(VEC[i][3:0]), got, VEC[i][11:4]);
            end
            OP_WR:   bus_write(VEC[i][13:12], VEC[i][11:4]);
            OP_WAIT: idle(48);
            default: idle(1);
         endcase
      end
      check(9, slave_rx, 8'hC3);          // R9 MSB-first shift of written byte

      // R1, R11: not early, then interrupt on completion
      bus_write(A_DATA, 8'h96);
      idle(10);
      #1 check(11, {7'd0, irq_o}, 8'h00);
      bus_read(A_STAT, got); check(1, got, 8'h00);   // R1 mid transfer
      idle(48);
      #1 check(11, {7'd0, irq_o}, 8'h01);            // R11
      bus_read(A_STAT, got); check(1, got, 8'h80);
      bus_read(A_DATA, got); check(9, got, 8'hA5);
      check(9, slave_rx, 8'h96);
      bus_read(A_STAT, got); check(2, got, 8'h00);

      // R12, R3, R4: re-collision after arming cancels the clear
      bus_write(A_DATA, 8'h3C);
      bus_write(A_DATA, 8'h11);
      #1 check(4, {7'd0, irq_o}, 8'h00);             // R4 no interrupt
      bus_read(A_STAT, got); check(3, got, 8'h40);
      bus_write(A_DATA, 8'h22);
      idle(48);
      bus_read(A_DATA, got); check(9, got, 8'hA5);
      bus_read(A_STAT, got); check(12, got, 8'hC0);  // R12 both remain
      check(3, slave_rx, 8'h3C);                      // R3 dropped writes
      bus_read(A_DATA, got);
      bus_read(A_STAT, got); check(4, got, 8'h00);

      // R11, R2: enable gating, control writes do not clear completion
      bus_write(A_DATA, 8'h5A);
      idle(48);
      bus_write(A_CTL, 8'h01);
      #1 check(11, {7'd0, irq_o}, 8'h00);
      bus_write(A_CTL, 8'h03);
      #1 check(11, {7'd0, irq_o}, 8'h01);
      bus_read(A_STAT, got); check(2, got, 8'h80);
      bus_read(A_DATA, got);

      // R5, R6, R8: mode fault
      ss_n_i = 1'b0;
      idle(6);
      bus_read(A_STAT, got); check(5, got, 8'h10);
      bus_read(A_CTL, got);  check(6, got, 8'h02);
      #1 check(11, {7'd0, irq_o}, 8'h01);
      bus_read(A_DATA, got);
      bus_read(A_STAT, got); check(8, got, 8'h10);   // data access no clear
      bus_write(A_CTL, 8'h02);
      bus_read(A_STAT, got); check(8, got, 8'h00);
      ss_n_i = 1'b1;
      idle(5);

      // R7: inhibited while slave select is an output
      ss_is_out_i = 1'b1;
      bus_write(A_CTL, 8'h03);
      ss_n_i = 1'b0;
      idle(6);
      bus_read(A_STAT, got); check(7, got, 8'h00);
      bus_read(A_CTL, got);  check(7, got, 8'h03);
      ss_n_i = 1'b1;
      idle(5);
      ss_is_out_i = 1'b0;
      idle(2);

      // R6, R13: fault aborts a running transfer
      bus_write(A_DATA, 8'hE7);
      idle(8);
      ss_n_i = 1'b0;
      idle(60);
      #1 check(13, {7'd0, sck_o}, 8'h00);
      bus_read(A_STAT, got); check(6, got, 8'h10);
      bus_read(A_CTL, got);  check(6, got, 8'h02);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule